// File: doc/BRIEF.md
# Multiplexed Four-Digit Hex Display Scanner

This block lights four common-anode seven-segment digits that share a single active-low segment bus. A free-running divider turns the fast system clock into a slow refresh tick. On every tick a small scan counter moves to the next digit. The block raises that digit's anode and puts the decoded shape of that digit's 4-bit value on the shared segment lines. With a 50 MHz clock and the default divider tap, the refresh runs at about 190 Hz per step.

The caller supplies a 16-bit value bus, one nibble per digit, and a 4-bit enable mask. A digit whose enable bit is clear stays dark because its anode is never raised. All sixteen hex values decode, so the display can show 0 to 9 and A to F. A synchronous reset restarts the divider and the scan, so scanning always begins at the leftmost digit.

Top module: `seg_scan_top`

## Requirements
- R1: The scan moves forward exactly once every 2^(TAP+1) clocks. After reset is released, the first step lands on clock number 2^TAP + 1, counting the first clock with reset low as number 1.
- R2: Scan slots run 0,1,2,3 and then wrap to 0. With all digits enabled, slot 0 drives anode 4'b1000, slot 1 drives 4'b0100, slot 2 drives 4'b0010 and slot 3 drives 4'b0001.
- R3: An anode bit `anode[p]` stays 0 whenever `digit_en[p]` is 0, including during the slot that selects digit p.
- R4: At most one anode bit is 1 in any cycle.
- R5: While the scan selects anode bit p, `seg_n` shows the decode of `digit_val[4p+3:4p]`.
- R6: `seg_n[6]` is segment a and `seg_n[0]` is segment g, and a 0 lights a segment. Values 0 to 9 give, as a..g: 0:0000001, 1:1001111, 2:0010010, 3:0000110, 4:1001100, 5:0100100, 6:0100000, 7:0001101, 8:0000000, 9:0000100.
- R7: Values 10 to 15 give the shapes A, b, C, d, E and F, as a..g: A:0001000, b:1100000, C:0110001, d:1000010, E:0110000, F:0111000.
- R8: While reset is high, and in the first cycle after reset is released, the scan is at slot 0. A reset in the middle of a run restarts the scan at slot 0.
- R9: The enable mask changes only the anodes. `seg_n` always shows the selected digit's decode, even when that digit is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| digit_val | input | 16 | One hex nibble per digit; nibble p belongs to anode bit p |
| digit_en | input | 4 | Per-digit enable; bit p gates anode bit p |
| anode | output | 4 | Active-high digit anode drive, at most one bit set |
| seg_n | output | 7 | Active-low segments, bit 6 = a down to bit 0 = g |

## Verification
Assertions check on every cycle that the anodes are never more than one-hot and that no anode rises against a clear enable bit. They also check that the divider counts by one each clock, that ticks never come back to back, that the scan holds between ticks, and that the scan sits at the first slot just after reset. Other behaviours can only be shown by the bench's scenarios: the exact step period and first-step delay, the full wrap order, the correct nibble on each digit, and all sixteen segment codes. The same is true of blanking under random masks and of a reset in the middle of a run.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

    localparam int SEG_W   = 7;
    localparam int NIBBLE_W = 4;

    typedef logic [SEG_W-1:0]    seg_code_t;
    typedef logic [NIBBLE_W-1:0] nibble_t;

endpackage

// File: rtl/seg_clk_div.sv
module seg_clk_div #(
    parameter int DIV_W = 24,
    parameter int TAP   = 17
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tap;
    } div_state_t;

    div_state_t div_d, div_q;

    always_comb begin
        div_d     = div_q;
        div_d.cnt = div_q.cnt + DIV_W'(1);
        div_d.tap = div_q.cnt[TAP];
        if (rst) begin
            div_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        div_q <= div_d;
    end

    // One tick when the tap bit rises
    assign tick_o = div_q.cnt[TAP] & ~div_q.tap;

    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> div_q.cnt == DIV_W'($past(div_q.cnt) + DIV_W'(1)));

    p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/seg_digit_scan.sv
module seg_digit_scan #(
    parameter int N_DIG  = 4,
    parameter int SLOT_W = (N_DIG > 1) ? $clog2(N_DIG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [N_DIG-1:0]  en_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic [N_DIG-1:0]  anode_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_DIG - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } scan_state_t;

    scan_state_t scan_d, scan_q;

    always_comb begin
        scan_d = scan_q;
        if (tick_i) begin
            if (scan_q.slot == LAST_SLOT) begin
                scan_d.slot = '0;
            end else begin
                scan_d.slot = scan_q.slot + SLOT_W'(1);
            end
        end
        if (rst) begin
            scan_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        scan_q <= scan_d;
    end

    assign slot_o = scan_q.slot;

    // Slot k lights the anode at bit N_DIG-1-k, gated by its enable
    for (genvar p = 0; p < N_DIG; p++) begin : g_anode
        assign anode_o[p] = en_i[p] && (scan_q.slot == SLOT_W'(N_DIG - 1 - p));
    end

    p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(anode_o));

    p_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (anode_o & ~en_i) == '0);

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(scan_q.slot));

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> scan_q.slot == '0);

endmodule

// File: rtl/seg_hex_dec.sv
module seg_hex_dec
    import seg_scan_pkg::*;
(
    input  nibble_t   nib_i,
    output seg_code_t seg_n_o
);

    // Bit 6 = segment a ... bit 0 = segment g, low lights
    always_comb begin
        case (nib_i)
            4'h0: seg_n_o = 7'b0000001;
            4'h1: seg_n_o = 7'b1001111;
            4'h2: seg_n_o = 7'b0010010;
            4'h3: seg_n_o = 7'b0000110;
            4'h4: seg_n_o = 7'b1001100;
            4'h5: seg_n_o = 7'b0100100;
            4'h6: seg_n_o = 7'b0100000;
            4'h7: seg_n_o = 7'b0001101;
            4'h8: seg_n_o = 7'b0000000;
            4'h9: seg_n_o = 7'b0000100;
            4'hA: seg_n_o = 7'b0001000;
            4'hB: seg_n_o = 7'b1100000;
            4'hC: seg_n_o = 7'b0110001;
            4'hD: seg_n_o = 7'b1000010;
            4'hE: seg_n_o = 7'b0110000;
            default: seg_n_o = 7'b0111000;
        endcase
    end

    always_comb begin
        if (nib_i == 4'h8) begin
            p_all_lit_r6: assert (seg_n_o == '0);
        end
        if (nib_i == 4'h1) begin
            p_two_lit_r6: assert ($countones(~seg_n_o) == 2);
        end
    end

endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top
    import seg_scan_pkg::*;
#(
    parameter int N_DIG = 4,
    parameter int DIV_W = 24,
    parameter int TAP   = 17
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_DIG*NIBBLE_W-1:0] digit_val,
    input  logic [N_DIG-1:0]        digit_en,
    output logic [N_DIG-1:0]        anode,
    output logic [SEG_W-1:0]        seg_n
);

    localparam int SLOT_W = (N_DIG > 1) ? $clog2(N_DIG) : 1;

    logic              tick;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] digit_idx;
    nibble_t           nib_arr [N_DIG];
    nibble_t           nib_sel;

    seg_clk_div #(
        .DIV_W (DIV_W),
        .TAP   (TAP)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    seg_digit_scan #(
        .N_DIG  (N_DIG),
        .SLOT_W (SLOT_W)
    ) u_scan (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .en_i    (digit_en),
        .slot_o  (slot),
        .anode_o (anode)
    );

    for (genvar g = 0; g < N_DIG; g++) begin : g_nib
        assign nib_arr[g] = digit_val[g*NIBBLE_W +: NIBBLE_W];
    end

    // Same index as the anode lit by this slot
    assign digit_idx = SLOT_W'(N_DIG - 1) - slot;
    assign nib_sel   = nib_arr[digit_idx];

    seg_hex_dec u_dec (
        .nib_i   (nib_sel),
        .seg_n_o (seg_n)
    );

endmodule

// File: tb/sim_seg_scan_top.sv
module sim_seg_scan_top;

    localparam int TAP    = 2;
    localparam int PERIOD = 1 << (TAP + 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] digit_val = '0;
    logic [3:0]  digit_en  = 4'hF;
    logic [3:0]  anode;
    logic [6:0]  seg_n;

    int n_chk = 0;
    int n_err = 0;
    int run_cyc = 0;
    bit done = 1'b0;

    seg_scan_top #(.N_DIG(4), .DIV_W(24), .TAP(TAP)) u0 (
        .clk       (clk),
        .rst       (rst),
        .digit_val (digit_val),
        .digit_en  (digit_en),
        .anode     (anode),
        .seg_n     (seg_n)
    );

    always #10 clk = ~clk;

    // Clocks seen with reset low since the last reset
    always @(posedge clk) begin
        if (rst) run_cyc <= 0;
        else     run_cyc <= run_cyc + 1;
    end

    function automatic logic [6:0] exp_seg(input logic [3:0] v);
        case (v)
            4'h0: return 7'b0000001;  4'h1: return 7'b1001111;
            4'h2: return 7'b0010010;  4'h3: return 7'b0000110;
            4'h4: return 7'b1001100;  4'h5: return 7'b0100100;
            4'h6: return 7'b0100000;  4'h7: return 7'b0001101;
            4'h8: return 7'b0000000;  4'h9: return 7'b0000100;
            4'hA: return 7'b0001000;  4'hB: return 7'b1100000;
            4'hC: return 7'b0110001;  4'hD: return 7'b1000010;
            4'hE: return 7'b0110000;  default: return 7'b0111000;
        endcase
    endfunction

    function automatic int exp_slot(input int cyc);
        return ((cyc + (1 << TAP) - 1) / PERIOD) % 4;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, exp, run_cyc);
        end
    endtask

    // Full check of both outputs against the bench model
    task automatic check_outputs(input string an_tag, input string seg_tag);
        int p = 3 - exp_slot(run_cyc);
        logic [3:0] ea = digit_en[p] ? 4'(1 << p) : 4'b0000;
        chk(digit_en[p] ? an_tag : "R3", int'(anode), int'(ea));
        chk(seg_tag, int'(seg_n), int'(exp_seg(digit_val[4*p +: 4])));
        chk("R4", int'($countones(anode) <= 1), 1);
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    initial begin
        int first_chg;
        int last_chg;
        logic [3:0] prev_an;
        void'($urandom(32'd4242));

        // Reset state
        digit_val = 16'h0123;
        repeat (3) step();
        chk("R8", int'(anode), 4'b1000);
        chk("R8", int'(seg_n), int'(exp_seg(4'h0)));
        rst = 1'b0;
        step();
        chk("R8", int'(anode), 4'b1000);
        check_outputs("R2", "R5");

        // Step timing: first step and spacing
        first_chg = -1;
        last_chg  = -1;
        prev_an   = anode;
        for (int i = 0; i < 5 * PERIOD; i++) begin
            step();
            check_outputs("R2", "R5");
            if (anode != prev_an) begin
                if (first_chg < 0) begin
                    first_chg = run_cyc;
                    chk("R1", first_chg, (1 << TAP) + 1);
                end else begin
                    chk("R1", run_cyc - last_chg, PERIOD);
                end
                last_chg = run_cyc;
                chk("R2", int'(anode), int'(prev_an == 4'b0001 ? 4'b1000 : prev_an >> 1));
            end
            prev_an = anode;
        end

        // All sixteen codes on every digit
        for (int v = 0; v < 16; v++) begin
            digit_val = {4{4'(v)}};
            for (int i = 0; i < 4 * PERIOD; i++) begin
                step();
                check_outputs("R2", v < 10 ? "R6" : "R7");
            end
        end

        // Everything blanked: anodes dark, segments still decode
        digit_val = 16'hC3A9;
        digit_en  = 4'h0;
        for (int i = 0; i < 4 * PERIOD; i++) begin
            step();
            chk("R3", int'(anode), 0);
            chk("R9", int'(seg_n), int'(exp_seg(digit_val[4*(3-exp_slot(run_cyc)) +: 4])));
        end

        // Random values and masks
        digit_en = 4'hF;
        for (int i = 0; i < 3000; i++) begin
            if (i % 5 == 0) begin
                digit_val = 16'($urandom);
                digit_en  = 4'($urandom);
            end
            step();
            check_outputs("R2", "R5");
        end

        // Mid-run reset restarts at the first slot
        digit_en = 4'hF;
        while (exp_slot(run_cyc) != 2) step();
        rst = 1'b1;
        step();
        step();
        chk("R8", int'(anode), 4'b1000);
        rst = 1'b0;
        step();
        chk("R8", int'(anode), 4'b1000);
        for (int i = 0; i < 2 * PERIOD; i++) begin
            step();
            check_outputs("R1", "R5");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule